// File: doc/BRIEF.md
# Debug Register Scan Access

This block is a target-side debug data register that sits behind a JTAG TAP. It gives an external debugger access to a small bank of 32-bit debug registers. These are debug control, debug status, vector catch, the two comms-channel registers and a set of watchpoint units. The TAP controller supplies one-cycle capture, shift and update enables in the TCK domain, together with serial data in. The block drives serial data out from the low end of its 38-bit shift register.

Each scan carries a 32-bit data word, a 5-bit register address and a direction flag. When the update enable arrives, a set flag writes the data word into the addressed register. A clear flag only selects the register to be read. The selected register's value is loaded on the next capture, so a debugger gets each value one scan after it names the address. Selecting the comms data register for a read consumes one word from the core side. Keeping that address scan after scan consumes successive words, so a read burst should end by selecting a harmless register such as comms control.

Top module: `dbg_scan_regs`

## Requirements
- R1: The shift register is 38 bits and is shifted least significant bit first. Bits 31:0 hold the data, bits 36:32 hold the address and bit 37 holds the direction flag (1 = write). TDO is bit 0 of the shift register. A capture loads the read value into bits 31:0 and zero into bits 37:32.
- R2: An update with flag 1 writes the data field into the addressed writable register. Writable registers change only on such an update, and the new value appears at the outputs in the cycle after the update.
- R3: An update with flag 0 selects the addressed register. The selected value appears in bits 31:0 of the next capture. An update with flag 1 leaves the selection unchanged.
- R4: Address 0x00 is debug control, 6 bits wide, and its bit 4 drives the monitor enable output. Address 0x01 reads the 5-bit debug status input and ignores writes. Address 0x02 is vector catch, VCATCH_W bits wide.
- R5: Watchpoint unit u occupies 0x08+8u to 0x0D+8u. Its six registers are, in address order: address value, address mask, data value, data mask, control value and control mask. The two control registers are WP_CTRL_W bits wide and the rest are 32 bits.
- R6: A read-select of address 0x05 latches the core's comms word and pulses comms_consume_o for one cycle, in the cycle after the update. Consecutive read-selects of 0x05 consume and return successive words.
- R7: A write to address 0x05 pulses comms_wr_o for one cycle after the update, with the data field on comms_wdata_o. It does not alter the word that a read of 0x05 returns.
- R8: Address 0x04 (comms control) reads as the VERSION parameter in bits 31:28, the core-side write flag in bit 1, the read flag in bit 0 and zero elsewhere. Writes to it are ignored.
- R9: Unmapped addresses read as zero and ignore writes. Bits above a register's width read as zero and are discarded on write.
- R10: After reset, all writable registers are zero, the comms latch is zero and the read selection is comms control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TCK-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| capture_dr_i | input | 1 | Capture enable from the TAP |
| shift_dr_i | input | 1 | Shift enable from the TAP |
| update_dr_i | input | 1 | Update enable from the TAP |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (shift register bit 0) |
| dbg_status_i | input | 5 | Core debug status, read at 0x01 |
| comms_rd_flag_i | input | 1 | Comms control bit 0 |
| comms_wr_flag_i | input | 1 | Comms control bit 1 |
| comms_rdata_i | input | 32 | Core-to-debugger comms word |
| comms_consume_o | output | 1 | One-cycle pulse: comms word taken |
| comms_wr_o | output | 1 | One-cycle pulse: debugger-to-core word |
| comms_wdata_o | output | 32 | Word written to the comms data register |
| dbg_ctrl_o | output | 6 | Debug control register |
| monitor_en_o | output | 1 | Monitor mode enable (debug control bit 4) |
| vcatch_o | output | VCATCH_W | Vector catch register |
| wp_regs_o | output | NUM_WP*192 | Watchpoint registers, 32-bit slots, unit-major |

## Verification
The assertions check several things on every cycle. Serial data enters the top of the shift register, and debug control never moves without a write enable. The comms strobes fire only in the cycle after an update and never together. Every capture of comms control carries the version field. The bench scenarios are needed to show the pipelined read. A value can only be judged one scan after its address was named, against a model of the selection and the latched comms word. This also covers burst consumption of successive words, the masking of narrow registers and the silence of unmapped or read-only addresses.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
   localparam int SCAN_LEN = 38;
   localparam int DATA_W   = 32;
   localparam int ADDR_W   = 5;
   localparam int WP_REGS  = 6;
   localparam int WP_SLOT  = WP_REGS * DATA_W;
   localparam int CTRL_W   = 6;
   localparam int STAT_W   = 5;
   localparam int MON_BIT  = 4;

   localparam logic [ADDR_W-1:0] A_DCTRL = 5'h00;
   localparam logic [ADDR_W-1:0] A_DSTAT = 5'h01;
   localparam logic [ADDR_W-1:0] A_VCAT  = 5'h02;
   localparam logic [ADDR_W-1:0] A_CCTRL = 5'h04;
   localparam logic [ADDR_W-1:0] A_CDATA = 5'h05;
   localparam int WP_BASE   = 8;
   localparam int WP_STRIDE = 8;

   typedef struct packed {
      logic              wr;
      logic [ADDR_W-1:0] addr;
      logic [DATA_W-1:0] data;
   } scan_word_t;

   function automatic logic [DATA_W-1:0] width_mask(input int w);
      if (w >= DATA_W) return '1;
      return (DATA_W'(1) << w) - DATA_W'(1);
   endfunction
endpackage

// File: rtl/dsc_shifter.sv
module dsc_shifter #(
   parameter int LEN = 38
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           capture_i,
   input  logic [LEN-1:0] load_i,
   input  logic           shift_i,
   input  logic           tdi_i,
   output logic [LEN-1:0] sr_o,
   output logic           tdo_o
);
   if (LEN < 2) begin : g_bad_len
      $error("dsc_shifter: LEN must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sr_o <= '0;
      else if (capture_i) sr_o <= load_i;
      else if (shift_i)   sr_o <= {tdi_i, sr_o[LEN-1:1]};
   end

   assign tdo_o = sr_o[0];

   AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_i && !capture_i) |=> (sr_o[LEN-1] == $past(tdi_i))); // R1
endmodule

// File: rtl/dsc_regbank.sv
module dsc_regbank
   import dsc_pkg::*;
#(
   parameter int VCATCH_W  = 8,
   parameter int NUM_WP    = 2,
   parameter int WP_CTRL_W = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en_i,
   input  logic [ADDR_W-1:0]         wr_addr_i,
   input  logic [DATA_W-1:0]         wr_data_i,
   output logic [CTRL_W-1:0]         ctrl_o,
   output logic [VCATCH_W-1:0]       vcatch_o,
   output logic [NUM_WP*WP_SLOT-1:0] wp_o
);
   if (VCATCH_W < 1 || VCATCH_W > DATA_W) begin : g_bad_vc
      $error("dsc_regbank: VCATCH_W out of range");
   end
   if (WP_CTRL_W < 1 || WP_CTRL_W > DATA_W) begin : g_bad_wpc
      $error("dsc_regbank: WP_CTRL_W out of range");
   end
   if (NUM_WP < 0 || NUM_WP > 3) begin : g_bad_wp
      $error("dsc_regbank: NUM_WP must fit the 5-bit address map");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_o   <= '0;
         vcatch_o <= '0;
      end else if (wr_en_i) begin
         if (wr_addr_i == A_DCTRL) ctrl_o   <= wr_data_i[CTRL_W-1:0];
         if (wr_addr_i == A_VCAT)  vcatch_o <= wr_data_i[VCATCH_W-1:0];
      end
   end

   for (genvar u = 0; u < NUM_WP; u++) begin : g_unit
      for (genvar r = 0; r < WP_REGS; r++) begin : g_reg
         localparam int              RW   = (r >= 4) ? WP_CTRL_W : DATA_W;
         localparam logic [DATA_W-1:0] MASK = width_mask(RW);
         localparam logic [ADDR_W-1:0] ADDR = ADDR_W'(WP_BASE + WP_STRIDE*u + r);
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            q <= '0;
            else if (wr_en_i && wr_addr_i == ADDR) q <= wr_data_i & MASK;
         end
         assign wp_o[(u*WP_REGS + r)*DATA_W +: DATA_W] = q;
      end
   end

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(ctrl_o)); // R2
endmodule

// File: rtl/dsc_readmux.sv
module dsc_readmux
   import dsc_pkg::*;
#(
   parameter int          VCATCH_W = 8,
   parameter int          NUM_WP   = 2,
   parameter logic [3:0]  VERSION  = 4'h6
) (
   input  logic [ADDR_W-1:0]         sel_i,
   input  logic [CTRL_W-1:0]         ctrl_i,
   input  logic [STAT_W-1:0]         status_i,
   input  logic [VCATCH_W-1:0]       vcatch_i,
   input  logic                      rd_flag_i,
   input  logic                      wr_flag_i,
   input  logic [DATA_W-1:0]         cdata_i,
   input  logic [NUM_WP*WP_SLOT-1:0] wp_i,
   output logic [DATA_W-1:0]         rdata_o
);
   always_comb begin
      rdata_o = '0;
      case (sel_i)
         A_DCTRL: rdata_o = DATA_W'(ctrl_i);
         A_DSTAT: rdata_o = DATA_W'(status_i);
         A_VCAT:  rdata_o = DATA_W'(vcatch_i);
         A_CCTRL: rdata_o = {VERSION, 26'd0, wr_flag_i, rd_flag_i};
         A_CDATA: rdata_o = cdata_i;
         default: begin
            for (int u = 0; u < NUM_WP; u++) begin
               for (int r = 0; r < WP_REGS; r++) begin
                  if (sel_i == ADDR_W'(WP_BASE + WP_STRIDE*u + r))
                     rdata_o = wp_i[(u*WP_REGS + r)*DATA_W +: DATA_W];
               end
            end
         end
      endcase
   end
endmodule

// File: rtl/dbg_scan_regs.sv
module dbg_scan_regs
   import dsc_pkg::*;
#(
   parameter int         VCATCH_W  = 8,
   parameter int         NUM_WP    = 2,
   parameter int         WP_CTRL_W = 9,
   parameter logic [3:0] VERSION   = 4'h6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      capture_dr_i,
   input  logic                      shift_dr_i,
   input  logic                      update_dr_i,
   input  logic                      tdi_i,
   output logic                      tdo_o,
   input  logic [4:0]                dbg_status_i,
   input  logic                      comms_rd_flag_i,
   input  logic                      comms_wr_flag_i,
   input  logic [31:0]               comms_rdata_i,
   output logic                      comms_consume_o,
   output logic                      comms_wr_o,
   output logic [31:0]               comms_wdata_o,
   output logic [5:0]                dbg_ctrl_o,
   output logic                      monitor_en_o,
   output logic [VCATCH_W-1:0]       vcatch_o,
   output logic [NUM_WP*192-1:0]     wp_regs_o
);
   localparam int HDR_W = SCAN_LEN - DATA_W;

   logic [SCAN_LEN-1:0] sr_q;
   scan_word_t          word;
   logic [ADDR_W-1:0]   rd_sel_q;
   logic [DATA_W-1:0]   cdata_q;
   logic [DATA_W-1:0]   rdata;
   logic                wr_upd, rd_upd;

   assign word   = scan_word_t'(sr_q);
   assign wr_upd = update_dr_i &&  word.wr;
   assign rd_upd = update_dr_i && !word.wr;

   dsc_shifter #(.LEN(SCAN_LEN)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (capture_dr_i),
      .load_i    ({{HDR_W{1'b0}}, rdata}),
      .shift_i   (shift_dr_i),
      .tdi_i     (tdi_i),
      .sr_o      (sr_q),
      .tdo_o     (tdo_o)
   );

   dsc_regbank #(.VCATCH_W(VCATCH_W), .NUM_WP(NUM_WP), .WP_CTRL_W(WP_CTRL_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_upd),
      .wr_addr_i (word.addr),
      .wr_data_i (word.data),
      .ctrl_o    (dbg_ctrl_o),
      .vcatch_o  (vcatch_o),
      .wp_o      (wp_regs_o)
   );

   dsc_readmux #(.VCATCH_W(VCATCH_W), .NUM_WP(NUM_WP), .VERSION(VERSION)) u_rmux (
      .sel_i     (rd_sel_q),
      .ctrl_i    (dbg_ctrl_o),
      .status_i  (dbg_status_i),
      .vcatch_i  (vcatch_o),
      .rd_flag_i (comms_rd_flag_i),
      .wr_flag_i (comms_wr_flag_i),
      .cdata_i   (cdata_q),
      .wp_i      (wp_regs_o),
      .rdata_o   (rdata)
   );

   // Read selection and comms data path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_sel_q        <= A_CCTRL;
         cdata_q         <= '0;
         comms_consume_o <= 1'b0;
         comms_wr_o      <= 1'b0;
         comms_wdata_o   <= '0;
      end else begin
         comms_consume_o <= rd_upd && (word.addr == A_CDATA);
         comms_wr_o      <= wr_upd && (word.addr == A_CDATA);
         if (rd_upd) begin
            rd_sel_q <= word.addr;
            if (word.addr == A_CDATA) cdata_q <= comms_rdata_i;
         end
         if (wr_upd && word.addr == A_CDATA) comms_wdata_o <= word.data;
      end
   end

   assign monitor_en_o = dbg_ctrl_o[MON_BIT];

   AST_CONSUME_AFTER_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      comms_consume_o |-> $past(update_dr_i)); // R6
   AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(comms_consume_o && comms_wr_o)); // R6
   AST_WRITE_AFTER_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      comms_wr_o |-> $past(update_dr_i)); // R7
   AST_VERSION_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
      (capture_dr_i && rd_sel_q == A_CCTRL) |=> (sr_q[31:28] == VERSION)); // R8
endmodule

// File: tb/dbg_scan_regs_bench.sv
module dbg_scan_regs_bench;
   localparam int         VCW = 8;
   localparam int         NWP = 2;
   localparam int         WPC = 9;
   localparam logic [3:0] VER = 4'h6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cap = 1'b0, shf = 1'b0, upd = 1'b0, tdi = 1'b0;
   logic tdo;
   logic [4:0]  status = '0;
   logic        rflag = 1'b0, wflag = 1'b0;
   logic [31:0] fifo_word = 32'hC0DE_0001;
   logic        consume, cwr;
   logic [31:0] cwdata;
   logic [5:0]  dctrl;
   logic        mon;
   logic [VCW-1:0] vcat;
   logic [NWP*192-1:0] wp;

   int n_tests = 0, n_fail = 0;
   int cons_cnt = 0, wr_cnt = 0;
   logic [31:0] last_wdata = '0;
   bit done = 0;

   // model state
   logic [4:0]  sel_m   = 5'h04;
   logic [31:0] latch_m = '0;
   logic [5:0]  ctrl_m  = '0;
   logic [7:0]  vcat_m  = '0;
   logic [31:0] wp_m [0:11];
   int exp_cons = 0, exp_wr = 0;
   logic [31:0] exp_wdata = '0;

   always #4 clk = ~clk;

   dbg_scan_regs #(.VCATCH_W(VCW), .NUM_WP(NWP), .WP_CTRL_W(WPC), .VERSION(VER)) u_dbg_scan_regs (
      .clk(clk), .rst_n(rst_n), .capture_dr_i(cap), .shift_dr_i(shf), .update_dr_i(upd),
      .tdi_i(tdi), .tdo_o(tdo), .dbg_status_i(status), .comms_rd_flag_i(rflag),
      .comms_wr_flag_i(wflag), .comms_rdata_i(fifo_word), .comms_consume_o(consume),
      .comms_wr_o(cwr), .comms_wdata_o(cwdata), .dbg_ctrl_o(dctrl), .monitor_en_o(mon),
      .vcatch_o(vcat), .wp_regs_o(wp));

   // core side of the comms channel
   always @(negedge clk) begin
      if (consume) begin
         cons_cnt  <= cons_cnt + 1;
         fifo_word <= fifo_word * 32'd1103515245 + 32'd12345;
      end
      if (cwr) begin
         wr_cnt     <= wr_cnt + 1;
         last_wdata <= cwdata;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int wp_index(input logic [4:0] a);
      int u, r;
      u = int'(a[4:3]) - 1;
      r = int'(a[2:0]);
      if (a >= 5'h08 && r < 6 && u < NWP) return u*6 + r;
      return -1;
   endfunction

   function automatic logic [31:0] model_read(input logic [4:0] a);
      int k;
      case (a)
         5'h00: return {26'd0, ctrl_m};
         5'h01: return {27'd0, status};
         5'h02: return {24'd0, vcat_m};
         5'h04: return {VER, 26'd0, wflag, rflag};
         5'h05: return latch_m;
         default: begin
            k = wp_index(a);
            if (k >= 0) return wp_m[k];
            return 32'd0;
         end
      endcase
   endfunction

   function automatic string req_of(input logic [4:0] a);
      case (a)
         5'h00, 5'h01, 5'h02: return "R4";
         5'h04: return "R8";
         5'h05: return "R6";
         default: return (wp_index(a) >= 0) ? "R5" : "R9";
      endcase
   endfunction

   task automatic scan(input logic wr, input logic [4:0] addr, input logic [31:0] data);
      logic [37:0] din, dout;
      logic [31:0] exp;
      string rq;
      int k;
      din = {wr, addr, data};
      exp = model_read(sel_m);
      rq  = req_of(sel_m);
      @(negedge clk) cap = 1'b1;
      @(negedge clk) begin cap = 1'b0; shf = 1'b1; end
      for (int i = 0; i < 38; i++) begin
         tdi = din[i];
         dout[i] = tdo;
         @(negedge clk);
      end
      shf = 1'b0; upd = 1'b1;
      // model update, sampled before the update edge
      if (wr) begin
         k = wp_index(addr);
         if (addr == 5'h00) ctrl_m = data[5:0];
         else if (addr == 5'h02) vcat_m = data[7:0];
         else if (addr == 5'h05) begin exp_wr++; exp_wdata = data; end
         else if (k >= 0) wp_m[k] = (k % 6 >= 4) ? (data & 32'h1FF) : data;
      end else begin
         sel_m = addr;
         if (addr == 5'h05) begin latch_m = fifo_word; exp_cons++; end
      end
      @(negedge clk) upd = 1'b0;
      @(negedge clk);
      chk({rq, " (R3 pipelined read)"}, dout[31:0], exp);
      chk("R1 header zero on capture", {26'd0, dout[37:32]}, 32'd0);
      chk("R2 debug control", {26'd0, dctrl}, {26'd0, ctrl_m});
      chk("R4 monitor enable", {31'd0, mon}, {31'd0, ctrl_m[4]});
      chk("R2 vector catch", {24'd0, vcat}, {24'd0, vcat_m});
      for (int j = 0; j < 12; j++) chk("R5 watchpoint output", wp[j*32 +: 32], wp_m[j]);
      chk("R6 consume count", 32'(cons_cnt), 32'(exp_cons));
      chk("R7 comms write count", 32'(wr_cnt), 32'(exp_wr));
      chk("R7 comms write data", last_wdata, exp_wdata);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      for (int j = 0; j < 12; j++) wp_m[j] = '0;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 ctrl reset", {26'd0, dctrl}, 32'd0);
      chk("R10 vcatch reset", {24'd0, vcat}, 32'd0);
      chk("R10 wp reset", wp[31:0], 32'd0);
      chk("R10 no strobe", {30'd0, consume, cwr}, 32'd0);
      rflag = 1'b1; status = 5'h15;
      // first capture returns comms control (R10 default selection, R8)
      scan(1'b0, 5'h00, 32'h0);
      // width masking, monitor bit (R9, R4)
      scan(1'b1, 5'h00, 32'hFFFF_FFFF);
      scan(1'b1, 5'h02, 32'hABCD_1234);
      scan(1'b0, 5'h02, 32'h0);
      scan(1'b0, 5'h01, 32'h0);
      // read-only and unmapped writes ignored (R4, R8, R9)
      scan(1'b1, 5'h01, 32'hFFFF_FFFF);
      scan(1'b1, 5'h04, 32'hFFFF_FFFF);
      scan(1'b1, 5'h03, 32'hFFFF_FFFF);
      scan(1'b1, 5'h0E, 32'hFFFF_FFFF);
      scan(1'b1, 5'h1F, 32'hFFFF_FFFF);
      scan(1'b0, 5'h04, 32'h0);
      scan(1'b0, 5'h03, 32'h0);
      scan(1'b0, 5'h0E, 32'h0);
      scan(1'b0, 5'h1F, 32'h0);
      // watchpoints R5
      for (int u = 0; u < NWP; u++)
         for (int r = 0; r < 6; r++)
            scan(1'b1, 5'(8 + 8*u + r), $urandom);
      for (int u = 0; u < NWP; u++)
         for (int r = 0; r < 6; r++)
            scan(1'b0, 5'(8 + 8*u + r), 32'h0);
      // comms read burst R6, then end on comms control
      wflag = 1'b1;
      scan(1'b0, 5'h05, 32'h0);
      scan(1'b0, 5'h05, 32'h0);
      scan(1'b0, 5'h05, 32'h0);
      scan(1'b0, 5'h04, 32'h0);
      // comms write R7, selection kept (R3)
      scan(1'b0, 5'h05, 32'h0);
      scan(1'b1, 5'h05, 32'h5A5A_F00D);
      scan(1'b1, 5'h00, 32'h0000_0010);
      scan(1'b0, 5'h00, 32'h0);
      scan(1'b0, 5'h04, 32'h0);
      // constrained random mix
      for (int n = 0; n < 300; n++) begin
         status = 5'($urandom);
         rflag  = 1'($urandom);
         wflag  = 1'($urandom);
         scan(1'($urandom), 5'($urandom_range(0, 31)), $urandom);
      end
      scan(1'b0, 5'h04, 32'h0);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule